// File: doc/BRIEF.md
# I2C Command Sequencer with Residual Tracking

This block sits between a host-facing register file and a byte-level I2C bus engine. When the host writes a 32-bit command word, the block decodes and checks it. An accepted command loads two residual byte counters. The front-end counter tracks bytes moved on the bus. The back-end counter tracks bytes moved between the host and the data FIFO. If the command asks for a START, the block raises a start request toward the bus engine and waits for an acknowledge or a NACK.

While a transfer is in progress, the block recomputes its status on every clock from its registered state, the FIFO fill level and two 4-bit watermarks. The status flags are data-request, high-water, low-water, command-complete and busy. The rule for data-request depends on the transfer direction. When both residual counters reach zero, the command completes. A STOP is then requested only if the command word asked for one. Without a STOP the bus stays held, so a follow-on command without a START continues the same transaction.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Bits are numbered from the MSB of the 32-bit command word. The START flag is bit 31, the address flag bit 30, read-continue bit 29, and the STOP flag bit 28. The 7-bit device address is bits 23:17, read-not-write is bit 16, and the byte length is bits 15:0. An accepted command loads both residual counters with the length and presents the address and direction on the outputs in the following cycle.
- R2: A command with the START, address and STOP flags all clear and a length of zero sets the invalid-command error and leaves the counters and the start request unchanged.
- R3: A command written while the block is not ready sets the invalid-command error and is ignored. The block is not ready while command-complete is clear or a start or stop request is outstanding.
- R4: An accepted command with the START flag raises start_req until start_ack or start_nack. start_ack sets busy. start_nack sets the NACK error and command-complete and leaves busy clear.
- R5: For a read, high_water is set when the FIFO count is at or above the high watermark. data_req is set when high_water is set and the count is nonzero, or when the front-end residual is zero.
- R6: For a write, low_water is set when the FIFO count is at or below the low watermark. data_req is set when the back-end residual is nonzero and either the free FIFO space is at least that residual or low_water is set.
- R7: When both residuals are zero during a transfer, data_req clears and command-complete sets. If the STOP flag was given, stop_req rises and is held until stop_ack, which clears busy. Otherwise busy stays set and a command without START is accepted as a continuation.
- R8: After reset, command-complete is set, busy and both errors are clear, and both residuals are zero.
- R9: Each front-end or back-end decrement strobe lowers its counter by one. A strobe on a counter that is already zero has no effect.
- R10: The error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| wm_high | input | 4 | High watermark (read direction) |
| wm_low | input | 4 | Low watermark (write direction) |
| fifo_count | input | CNT_W | Current FIFO fill level |
| fe_dec | input | 1 | Front-end residual decrement strobe |
| be_dec | input | 1 | Back-end residual decrement strobe |
| start_ack | input | 1 | Bus engine: START and address acknowledged |
| start_nack | input | 1 | Bus engine: address not acknowledged |
| stop_ack | input | 1 | Bus engine: STOP done |
| start_req | output | 1 | Request START plus address |
| stop_req | output | 1 | Request STOP |
| dev_addr | output | 7 | Device address of the current command |
| xfer_read | output | 1 | Current command is a read |
| read_cont | output | 1 | Read-continue flag of the current command |
| busy | output | 1 | Bus held by this block |
| cmd_done | output | 1 | Command complete |
| data_req | output | 1 | Host data service requested |
| high_water | output | 1 | Read FIFO at or above high watermark |
| low_water | output | 1 | Write FIFO at or below low watermark |
| err_invalid | output | 1 | Invalid-command error |
| err_nack | output | 1 | Address NACK error |
| fe_left | output | 16 | Front-end residual |
| be_left | output | 16 | Back-end residual |

## Verification
Two events can land in the same cycle. One is the last residual decrement that completes a command. The other is the STOP decision that the same completion triggers. The bench reaches this by draining a write's back-end residual and then its front-end residual. It then checks that command-complete and stop_req rise together while busy is still held. A second collision comes from writing a command while a START is still pending. The bench judges this by the invalid-command flag and by residuals that keep their earlier values.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int WM_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_word,
  input  logic [WM_W-1:0]  wm_high,
  input  logic [WM_W-1:0]  wm_low,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fe_dec,
  input  logic             be_dec,
  input  logic             start_ack,
  input  logic             start_nack,
  input  logic             stop_ack,
  output logic             start_req,
  output logic             stop_req,
  output logic [6:0]       dev_addr,
  output logic             xfer_read,
  output logic             read_cont,
  output logic             busy,
  output logic             cmd_done,
  output logic             data_req,
  output logic             high_water,
  output logic             low_water,
  output logic             err_invalid,
  output logic             err_nack,
  output logic [15:0]      fe_left,
  output logic [15:0]      be_left
);

  localparam int LEN_W   = 16;
  localparam int B_START = 31;
  localparam int B_ADDR  = 30;
  localparam int B_CONT  = 29;
  localparam int B_STOP  = 28;
  localparam int A_HI    = 23;
  localparam int A_LO    = 17;
  localparam int B_RNW   = 16;

  logic             start_q, stop_q, busy_q, done_q, stop_flag_q;
  logic             rd_q, cont_q, einv_q, enack_q;
  logic             dr_q, hw_q, lw_q;
  logic [6:0]       addr_q;
  logic [LEN_W-1:0] fe_q, be_q;

  wire c_start = cmd_word[B_START];
  wire c_addr  = cmd_word[B_ADDR];
  wire c_stop  = cmd_word[B_STOP];
  wire [LEN_W-1:0] c_len = cmd_word[LEN_W-1:0];

  wire fmt_bad = !(c_start || c_addr || c_stop) && (c_len == '0);
  wire ready   = done_q && !start_q && !stop_q;
  wire accept  = cmd_wr && !fmt_bad && ready;
  wire reject  = cmd_wr && !accept;
  wire drained = (fe_q == '0) && (be_q == '0);
  wire finish  = busy_q && !start_q && !stop_q && !done_q && drained;

  wire [LEN_W:0] free_sp = (LEN_W+1)'(FIFO_DEPTH) - (LEN_W+1)'(fifo_count);

  logic hw_n, lw_n, dr_n;
  always_comb begin
    hw_n = busy_q && rd_q  && (32'(fifo_count) >= 32'(wm_high));
    lw_n = busy_q && !rd_q && (32'(fifo_count) <= 32'(wm_low));
    dr_n = 1'b0;
    if (busy_q && !start_q && !done_q && !drained) begin
      if (rd_q)
        dr_n = (hw_n && fifo_count != '0) || (fe_q == '0);
      else
        dr_n = (be_q != '0) && ((free_sp >= {1'b0, be_q}) || lw_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q     <= 1'b0;
      stop_q      <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b1;
      stop_flag_q <= 1'b0;
      rd_q        <= 1'b0;
      cont_q      <= 1'b0;
      addr_q      <= '0;
      fe_q        <= '0;
      be_q        <= '0;
      einv_q      <= 1'b0;
      enack_q     <= 1'b0;
      dr_q        <= 1'b0;
      hw_q        <= 1'b0;
      lw_q        <= 1'b0;
    end else begin
      dr_q <= dr_n;
      hw_q <= hw_n;
      lw_q <= lw_n;

      if (accept) begin
        fe_q        <= c_len;
        be_q        <= c_len;
        addr_q      <= cmd_word[A_HI:A_LO];
        rd_q        <= cmd_word[B_RNW];
        cont_q      <= cmd_word[B_CONT];
        stop_flag_q <= c_stop;
        if (c_start) start_q <= 1'b1;
        if (c_start || busy_q) done_q <= 1'b0;
      end else begin
        if (fe_dec && fe_q != '0) fe_q <= fe_q - 1'b1;
        if (be_dec && be_q != '0) be_q <= be_q - 1'b1;
      end

      if (reject) einv_q <= 1'b1;

      if (start_q && start_ack) begin
        start_q <= 1'b0;
        busy_q  <= 1'b1;
      end else if (start_q && start_nack) begin
        start_q <= 1'b0;
        enack_q <= 1'b1;
        done_q  <= 1'b1;
      end

      if (finish) begin
        done_q <= 1'b1;
        if (stop_flag_q) stop_q <= 1'b1;
      end

      if (stop_q && stop_ack) begin
        stop_q <= 1'b0;
        busy_q <= 1'b0;
      end
    end
  end

  assign start_req   = start_q;
  assign stop_req    = stop_q;
  assign dev_addr    = addr_q;
  assign xfer_read   = rd_q;
  assign read_cont   = cont_q;
  assign busy        = busy_q;
  assign cmd_done    = done_q;
  assign data_req    = dr_q;
  assign high_water  = hw_q;
  assign low_water   = lw_q;
  assign err_invalid = einv_q;
  assign err_nack    = enack_q;
  assign fe_left     = fe_q;
  assign be_left     = be_q;

  assert_bad_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[31:28] == 4'b0000 && cmd_word[15:0] == 16'h0) |=> err_invalid);

  assert_reject_unready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_done) |=> err_invalid);

  assert_start_from_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_req) |-> ($past(cmd_wr) && $past(cmd_word[31])));

  assert_busy_from_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req && start_ack));

  assert_dreq_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> (busy && !cmd_done));

  assert_stop_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (fe_left == 16'h0 && be_left == 16'h0 && cmd_done));

  assert_fe_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (fe_left <= $past(fe_left)));

  assert_be_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (be_left <= $past(be_left)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_invalid || err_nack) |=> ((err_invalid || !$past(err_invalid)) &&
                                   (err_nack || !$past(err_nack))));

endmodule

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
  localparam int CNT_W = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0;
  logic [31:0] cmd_word = '0;
  logic [3:0] wm_high = '0, wm_low = '0;
  logic [CNT_W-1:0] fifo_count = '0;
  logic fe_dec = 0, be_dec = 0, start_ack = 0, start_nack = 0, stop_ack = 0;
  logic start_req, stop_req, xfer_read, read_cont, busy, cmd_done;
  logic data_req, high_water, low_water, err_invalid, err_nack;
  logic [6:0] dev_addr;
  logic [15:0] fe_left, be_left;

  always #4 clk = ~clk;

  i2c_cmd_seq u_i2c_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .wm_high(wm_high), .wm_low(wm_low), .fifo_count(fifo_count),
    .fe_dec(fe_dec), .be_dec(be_dec), .start_ack(start_ack),
    .start_nack(start_nack), .stop_ack(stop_ack), .start_req(start_req),
    .stop_req(stop_req), .dev_addr(dev_addr), .xfer_read(xfer_read),
    .read_cont(read_cont), .busy(busy), .cmd_done(cmd_done),
    .data_req(data_req), .high_water(high_water), .low_water(low_water),
    .err_invalid(err_invalid), .err_nack(err_nack),
    .fe_left(fe_left), .be_left(be_left)
  );

  typedef enum int {S_DREQ, S_DONE, S_BUSY, S_HW, S_LW, S_EINV, S_ENACK,
                    S_START, S_STOP, S_FE, S_BE, S_ADDR, S_RD} sel_t;
  typedef struct {
    sel_t        sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event sample_ev;
  int total = 0, bad = 0;
  bit finished = 0;

  function automatic logic [31:0] observe(sel_t s);
    case (s)
      S_DREQ:  return 32'(data_req);
      S_DONE:  return 32'(cmd_done);
      S_BUSY:  return 32'(busy);
      S_HW:    return 32'(high_water);
      S_LW:    return 32'(low_water);
      S_EINV:  return 32'(err_invalid);
      S_ENACK: return 32'(err_nack);
      S_START: return 32'(start_req);
      S_STOP:  return 32'(stop_req);
      S_FE:    return 32'(fe_left);
      S_BE:    return 32'(be_left);
      S_ADDR:  return 32'(dev_addr);
      default: return 32'(xfer_read);
    endcase
  endfunction

  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = observe(it.sel);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s %s: actual=%0h expected=%0h", it.tag, it.sel.name(), act, it.exp);
      end
    end
  end

  task automatic expect_v(sel_t s, logic [31:0] v, string tag);
    item_t it;
    it.sel = s; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic flush();
    -> sample_ev;
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_wr = 0; fe_dec = 0; be_dec = 0;
    start_ack = 0; start_nack = 0; stop_ack = 0;
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  task automatic send_cmd(logic [31:0] w);
    cmd_word = w; cmd_wr = 1; tick(1); cmd_wr = 0;
  endtask

  task automatic pulse_fe(); fe_dec = 1; tick(1); fe_dec = 0; endtask
  task automatic pulse_be(); be_dec = 1; tick(1); be_dec = 0; endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R8 reset state
    expect_v(S_DONE, 1, "R8"); expect_v(S_BUSY, 0, "R8");
    expect_v(S_EINV, 0, "R8"); expect_v(S_ENACK, 0, "R8");
    expect_v(S_FE, 0, "R8");   expect_v(S_BE, 0, "R8");
    expect_v(S_START, 0, "R8"); expect_v(S_DREQ, 0, "R8");
    flush();

    // R2 all flags clear, zero length
    send_cmd(32'h0000_0000);
    expect_v(S_EINV, 1, "R2"); expect_v(S_FE, 0, "R2");
    expect_v(S_START, 0, "R2"); expect_v(S_DONE, 1, "R2");
    flush();
    tick(3);
    expect_v(S_EINV, 1, "R10"); flush();

    // Write transfer with START and STOP
    do_reset();
    wm_high = 4'd6; wm_low = 4'd2; fifo_count = 0;
    send_cmd(32'hD000_0000 | (32'h50 << 17) | 32'd3);
    expect_v(S_START, 1, "R4"); expect_v(S_FE, 3, "R1"); expect_v(S_BE, 3, "R1");
    expect_v(S_DONE, 0, "R1"); expect_v(S_ADDR, 32'h50, "R1"); expect_v(S_RD, 0, "R1");
    expect_v(S_BUSY, 0, "R4");
    flush();
    send_cmd(32'hD000_0000 | (32'h11 << 17) | 32'd9);
    expect_v(S_EINV, 1, "R3"); expect_v(S_FE, 3, "R3"); expect_v(S_ADDR, 32'h50, "R3");
    flush();
    start_ack = 1; tick(1); start_ack = 0;
    expect_v(S_BUSY, 1, "R4"); expect_v(S_START, 0, "R4"); flush();
    tick(1);
    expect_v(S_DREQ, 1, "R6"); expect_v(S_LW, 1, "R6"); flush();
    fifo_count = 7; tick(1);
    expect_v(S_DREQ, 0, "R6"); expect_v(S_LW, 0, "R6"); flush();
    wm_low = 4'd6; fifo_count = 6; tick(1);
    expect_v(S_LW, 1, "R6"); expect_v(S_DREQ, 1, "R6"); flush();
    wm_low = 4'd2; fifo_count = 7;
    pulse_be(); tick(1);
    expect_v(S_BE, 2, "R9"); expect_v(S_DREQ, 0, "R6"); flush();
    pulse_be(); tick(1);
    expect_v(S_BE, 1, "R9"); expect_v(S_DREQ, 1, "R6"); flush();
    pulse_be(); tick(1);
    expect_v(S_BE, 0, "R9"); expect_v(S_DREQ, 0, "R6"); expect_v(S_DONE, 0, "R7"); flush();
    pulse_be();
    expect_v(S_BE, 0, "R9"); flush();
    pulse_fe(); pulse_fe(); pulse_fe();
    expect_v(S_FE, 0, "R9"); expect_v(S_DONE, 0, "R7"); flush();
    tick(1);
    expect_v(S_DONE, 1, "R7"); expect_v(S_STOP, 1, "R7");
    expect_v(S_BUSY, 1, "R7"); expect_v(S_DREQ, 0, "R7"); flush();
    stop_ack = 1; tick(1); stop_ack = 0;
    expect_v(S_BUSY, 0, "R7"); expect_v(S_STOP, 0, "R7");
    expect_v(S_DONE, 1, "R7"); expect_v(S_EINV, 1, "R10"); flush();

    // Read transfer with START, no STOP, then continuation
    do_reset();
    wm_high = 4'd4; fifo_count = 3;
    send_cmd(32'hC000_0000 | (32'h2A << 17) | (32'h1 << 16) | 32'd2);
    expect_v(S_RD, 1, "R1"); expect_v(S_ADDR, 32'h2A, "R1"); flush();
    start_ack = 1; tick(1); start_ack = 0;
    tick(1);
    expect_v(S_HW, 0, "R5"); expect_v(S_DREQ, 0, "R5"); flush();
    fifo_count = 4; tick(1);
    expect_v(S_HW, 1, "R5"); expect_v(S_DREQ, 1, "R5"); flush();
    wm_high = 4'd0; fifo_count = 0; tick(1);
    expect_v(S_HW, 1, "R5"); expect_v(S_DREQ, 0, "R5"); flush();
    pulse_fe(); pulse_fe(); tick(1);
    expect_v(S_FE, 0, "R5"); expect_v(S_DREQ, 1, "R5"); expect_v(S_DONE, 0, "R7"); flush();
    pulse_be(); pulse_be(); tick(1);
    expect_v(S_DONE, 1, "R7"); expect_v(S_DREQ, 0, "R7");
    expect_v(S_STOP, 0, "R7"); expect_v(S_BUSY, 1, "R7"); flush();
    send_cmd((32'h1 << 16) | 32'd1);
    expect_v(S_FE, 1, "R7"); expect_v(S_DONE, 0, "R7");
    expect_v(S_START, 0, "R7"); expect_v(S_BUSY, 1, "R7"); expect_v(S_EINV, 0, "R7");
    flush();

    // Address NACK
    do_reset();
    send_cmd(32'hC000_0000 | (32'h33 << 17) | 32'd1);
    expect_v(S_START, 1, "R4"); flush();
    start_nack = 1; tick(1); start_nack = 0;
    expect_v(S_ENACK, 1, "R4"); expect_v(S_DONE, 1, "R4");
    expect_v(S_BUSY, 0, "R4"); expect_v(S_START, 0, "R4"); flush();
    tick(2);
    expect_v(S_ENACK, 1, "R10"); flush();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule